// File: doc/BRIEF.md
# Half-Bridge Desaturation Fault Qualifier

This block qualifies short-circuit faults for one half-bridge phase (one high-side and one low-side power switch). For each switch it takes a digital flag from an external comparator that is high when the switch's drain-source voltage is above the programmed limit. It also takes a strobe that is high while the switch is commanded on and its dead time has expired. After a turn-on blanking window, a qualified over-limit condition on either switch drives one up/down integrator. That integrator is shared by the phase. When the integrator reaches its threshold, a sticky short-circuit fault is raised. The fault holds until an external clear strobe arrives.

A second, independent path watches the flag that reports an open threshold-setting input. It raises a self-clearing open-pin fault once that flag has been steady for its own filter time. A full bridge uses two instances, one per phase.

All time windows are parameters in clock cycles. `BLANK_CYC` sets the blanking length, `FILT_CYC` sets the integrator threshold, and `OPEN_CYC` sets the open-pin qualification length. Both outputs are low after a synchronous active-high reset.

Top module: `desat_phase_filter`

## Requirements
- R1: After reset both `sc_fault_o` and `open_fault_o` are low and the integrator is empty.
- R2: An over-limit flag is ignored until its switch's on-strobe has been high for `BLANK_CYC` consecutive clock edges. A low strobe restarts the blanking window.
- R3: Each clock edge with a qualified over-limit condition adds one to the integrator. `sc_fault_o` goes high at the edge where the integrator reaches `FILT_CYC`, so from empty that is `FILT_CYC` qualified edges.
- R4: Each clock edge without a qualified over-limit condition subtracts one from the integrator. This is the same rate as counting up.
- R5: While a switch's on-strobe is low, its flag does not qualify, so the integrator discharges.
- R6: The high-side and low-side switches feed one integrator. Qualified edges from either switch accumulate together.
- R7: The integrator saturates at zero and at `FILT_CYC`.
- R8: `sc_fault_o` stays high until `fault_clr_i` is sampled high. If a qualified violation is present while the integrator is at `FILT_CYC` or `FILT_CYC-1`, setting wins over clearing.
- R9: `open_fault_o` goes high once `open_raw_i` has been sampled high on `OPEN_CYC` consecutive edges. It drops after the first edge that samples `open_raw_i` low.
- R10: `fault_clr_i` has no effect on `open_fault_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_on_i | input | 1 | High-side switch on and its dead time expired |
| hi_over_i | input | 1 | High-side drain-source voltage above limit |
| lo_on_i | input | 1 | Low-side switch on and its dead time expired |
| lo_over_i | input | 1 | Low-side drain-source voltage above limit |
| open_raw_i | input | 1 | Threshold input reported open (unfiltered) |
| fault_clr_i | input | 1 | Clears the sticky short-circuit fault |
| sc_fault_o | output | 1 | Latched short-circuit fault |
| open_fault_o | output | 1 | Filtered, self-clearing open-pin fault |

## Verification
The integrator is driven with several input patterns:
- An over-limit flag confined to the blanking window, which separates correct blanking from premature monitoring.
- A steady over-limit run, which fixes the exact edge at which the fault rises.
- An alternating flag at a one-to-one ratio, which must never trip and so exposes any asymmetry between the up and down rates.
- A two-to-one ratio, which must trip and so shows that the integrator is not a consecutive-sample debounce.

Switching the high side off mid-charge shows the discharge-while-off behaviour and the restart of blanking. Handing a partial charge from the high-side switch to the low-side switch shows that the two switches share one integrator. The open-pin flag is driven with pulses shorter and longer than its filter, and with clear strobes, to separate it from the sticky path.

// File: rtl/desat_pkg.sv
package desat_pkg;

    // Number of switches in one phase (high side, low side)
    localparam int NUM_LEGS = 2;

    typedef enum int {
        LEG_HIGH = 0,
        LEG_LOW  = 1
    } leg_e;

    // Per-switch inputs seen by the blanking stage
    typedef struct packed {
        logic on_ok;   // commanded on, dead time over
        logic over;    // drain-source above limit
    } leg_in_t;

    // Integrator move chosen each cycle
    typedef enum logic [1:0] {
        INT_HOLD = 2'd0,
        INT_UP   = 2'd1,
        INT_DOWN = 2'd2
    } int_dir_e;

    // Bits needed to hold values 0..maxval
    function automatic int cnt_bits(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/desat_blank_timer.sv
module desat_blank_timer
    import desat_pkg::*;
#(
    parameter int BLANK_CYC = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  leg_in_t leg_i,
    output logic    qual_o
);

    localparam int            W   = cnt_bits(BLANK_CYC);
    localparam logic [W-1:0]  LIM = W'(BLANK_CYC);

    logic [W-1:0] cnt_q;
    logic         armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!leg_i.on_ok) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign armed  = leg_i.on_ok && (cnt_q == LIM);
    assign qual_o = armed && leg_i.over;

    // R2
    blank_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !leg_i.on_ok |=> (cnt_q == '0));

    // R2
    blank_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);

endmodule

// File: rtl/desat_integrator.sv
module desat_integrator
    import desat_pkg::*;
#(
    parameter int FILT_CYC = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_LEGS-1:0] qual_i,
    input  logic                clr_i,
    output logic                sc_fault_o
);

    localparam int           W      = cnt_bits(FILT_CYC);
    localparam logic [W-1:0] LIM    = W'(FILT_CYC);
    localparam logic [W-1:0] LIM_M1 = W'(FILT_CYC - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         viol;
    logic         set_now;
    int_dir_e     dir;

    assign viol = |qual_i;

    always_comb begin
        if (viol && cnt_q != LIM)
            dir = INT_UP;
        else if (!viol && cnt_q != '0)
            dir = INT_DOWN;
        else
            dir = INT_HOLD;
    end

    always_comb begin
        case (dir)
            INT_UP:   cnt_d = cnt_q + 1'b1;
            INT_DOWN: cnt_d = cnt_q - 1'b1;
            default:  cnt_d = cnt_q;
        endcase
    end

    assign set_now = viol && (cnt_q >= LIM_M1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            sc_fault_o <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            sc_fault_o <= set_now | (sc_fault_o & ~clr_i);
        end
    end

    // R7
    int_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);

    // R3
    int_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (viol && cnt_q == LIM) |=> sc_fault_o);

    // R4
    int_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!viol && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sc_fault_o && !clr_i) |=> sc_fault_o);

endmodule

// File: rtl/desat_open_filter.sv
module desat_open_filter
    import desat_pkg::*;
#(
    parameter int OPEN_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic open_o
);

    localparam int           W   = cnt_bits(OPEN_CYC);
    localparam logic [W-1:0] LIM = W'(OPEN_CYC);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!raw_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign open_o = (cnt_q == LIM);

    // R9
    open_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !raw_i |=> !open_o);

endmodule

// File: rtl/desat_phase_filter.sv
module desat_phase_filter
    import desat_pkg::*;
#(
    parameter int BLANK_CYC = 8,
    parameter int FILT_CYC  = 16,
    parameter int OPEN_CYC  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_on_i,
    input  logic hi_over_i,
    input  logic lo_on_i,
    input  logic lo_over_i,
    input  logic open_raw_i,
    input  logic fault_clr_i,
    output logic sc_fault_o,
    output logic open_fault_o
);

    leg_in_t [NUM_LEGS-1:0] legs;
    logic    [NUM_LEGS-1:0] qual;

    assign legs[LEG_HIGH] = '{on_ok: hi_on_i, over: hi_over_i};
    assign legs[LEG_LOW]  = '{on_ok: lo_on_i, over: lo_over_i};

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        desat_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
            .clk    (clk),
            .rst    (rst),
            .leg_i  (legs[g]),
            .qual_o (qual[g])
        );
    end

    desat_integrator #(.FILT_CYC(FILT_CYC)) u_integ (
        .clk        (clk),
        .rst        (rst),
        .qual_i     (qual),
        .clr_i      (fault_clr_i),
        .sc_fault_o (sc_fault_o)
    );

    desat_open_filter #(.OPEN_CYC(OPEN_CYC)) u_open (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (open_raw_i),
        .open_o (open_fault_o)
    );

    // R10
    open_clr_indep_chk: assert property (@(posedge clk) disable iff (rst)
        (open_fault_o && open_raw_i && fault_clr_i) |=> open_fault_o);

endmodule

// File: tb/desat_phase_filter_tb.sv
module desat_phase_filter_tb;

    localparam int BLANK = 4;
    localparam int FILT  = 6;
    localparam int OPEN  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi_on = 0, hi_over = 0, lo_on = 0, lo_over = 0;
    logic open_raw = 0, clr = 0;
    logic sc_fault, open_fault;

    always #2 clk = ~clk;   // 250 MHz

    desat_phase_filter #(.BLANK_CYC(BLANK), .FILT_CYC(FILT), .OPEN_CYC(OPEN)) u_dut (
        .clk(clk), .rst(rst),
        .hi_on_i(hi_on), .hi_over_i(hi_over),
        .lo_on_i(lo_on), .lo_over_i(lo_over),
        .open_raw_i(open_raw), .fault_clr_i(clr),
        .sc_fault_o(sc_fault), .open_fault_o(open_fault)
    );

    // Behavioural reference model
    int  m_hb, m_lb, m_int, m_ocnt;
    bit  m_sc;
    int  n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit  done = 0;

    always @(posedge clk) begin
        bit qh, ql, v;
        if (rst) begin
            m_hb = 0; m_lb = 0; m_int = 0; m_ocnt = 0; m_sc = 0;
        end else begin
            qh = hi_on && hi_over && (m_hb == BLANK);
            ql = lo_on && lo_over && (m_lb == BLANK);
            v  = qh || ql;
            m_hb = hi_on ? ((m_hb < BLANK) ? m_hb + 1 : m_hb) : 0;
            m_lb = lo_on ? ((m_lb < BLANK) ? m_lb + 1 : m_lb) : 0;
            m_sc = (v && m_int >= FILT - 1) || (m_sc && !clr);
            if (v) m_int = (m_int < FILT) ? m_int + 1 : FILT;
            else   m_int = (m_int > 0) ? m_int - 1 : 0;
            m_ocnt = open_raw ? ((m_ocnt < OPEN) ? m_ocnt + 1 : OPEN) : 0;
        end
    end

    task automatic compare();
        n_cmp++;
        if (sc_fault !== m_sc) begin
            n_bad++;
            $display("FAIL %s sc_fault actual=%0b expected=%0b t=%0t", cur_req, sc_fault, m_sc, $time);
        end
        n_cmp++;
        if (open_fault !== (m_ocnt == OPEN)) begin
            n_bad++;
            $display("FAIL %s open_fault actual=%0b expected=%0b t=%0t", cur_req, open_fault, (m_ocnt == OPEN), $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    // Direct check of a fixed expected value, worked out from the requirements
    task automatic expect_sc(input bit exp, input string req);
        n_cmp++;
        if (sc_fault !== exp) begin
            n_bad++;
            $display("FAIL %s direct sc_fault actual=%0b expected=%0b", req, sc_fault, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        rst = 0;
        tick(2);
        expect_sc(0, "R1");

        // R2: over-limit only inside the blanking window is ignored
        cur_req = "R2";
        hi_on = 1; hi_over = 1;
        tick(BLANK);
        hi_on = 0; hi_over = 0;
        tick(3);
        expect_sc(0, "R2");
        // R2: blanking restarts; charge to FILT-1 then stop
        hi_on = 1; hi_over = 1;
        tick(BLANK + FILT - 1);
        expect_sc(0, "R2");
        // R4: discharge at same rate, then R7 floor at zero
        cur_req = "R4";
        hi_over = 0;
        tick(FILT + 3);
        hi_over = 1;
        tick(FILT - 1);
        expect_sc(0, "R7");   // empty floor: FILT-1 more edges does not trip
        // R3: one more qualified edge reaches threshold
        cur_req = "R3";
        tick(1);
        expect_sc(1, "R3");
        // R7: saturate high; R8: clear while violation persists is overridden
        cur_req = "R8";
        tick(4);
        clr = 1;
        tick(2);
        expect_sc(1, "R8");
        clr = 0;
        hi_over = 0;
        tick(2);
        expect_sc(1, "R8");   // sticky without clear
        clr = 1;
        tick(1);
        clr = 0;
        expect_sc(0, "R8");
        tick(FILT + 2);

        // R4: one-to-one toggling must never trip
        cur_req = "R4";
        for (int k = 0; k < 20; k++) begin
            hi_over = ~hi_over;
            tick(1);
        end
        expect_sc(0, "R4");
        hi_over = 0;
        tick(FILT + 2);
        // R3: two-up one-down pattern must trip eventually
        cur_req = "R3";
        for (int k = 0; k < 12; k++) begin
            hi_over = 1; tick(2);
            hi_over = 0; tick(1);
        end
        expect_sc(1, "R3");
        clr = 1; tick(1); clr = 0;
        tick(FILT + 2);

        // R5: switch turned off mid-charge discharges and restarts blanking
        cur_req = "R5";
        hi_over = 1;
        tick(FILT - 1);        // already armed: integrator at FILT-1
        hi_on = 0;
        tick(3);               // discharges to FILT-4
        hi_on = 1;
        tick(BLANK);           // blanking again, keeps discharging to 0
        tick(FILT - 1);
        expect_sc(0, "R5");
        tick(1);
        expect_sc(1, "R5");
        hi_on = 0; hi_over = 0;
        clr = 1; tick(1); clr = 0;
        tick(FILT + 2);

        // R6: shared integrator across both switches
        cur_req = "R6";
        lo_on = 1;
        hi_on = 1;
        tick(BLANK + 1);
        hi_over = 1;
        tick(3);
        hi_over = 0; hi_on = 0;
        lo_over = 1;
        tick(2);
        expect_sc(0, "R6");
        tick(1);
        expect_sc(1, "R6");
        lo_over = 0; lo_on = 0;
        clr = 1; tick(1); clr = 0;
        tick(FILT + 2);

        // R9: short open pulse filtered, long one passes, then self-clears
        cur_req = "R9";
        open_raw = 1;
        tick(OPEN - 1);
        open_raw = 0;
        tick(2);
        open_raw = 1;
        tick(OPEN + 2);
        // R10: clear does not touch open fault
        cur_req = "R10";
        clr = 1;
        tick(3);
        clr = 0;
        cur_req = "R9";
        open_raw = 0;
        tick(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule